// File: doc/BRIEF.md
# External Data Bus Stretch Sequencer

This block runs one external data-memory transfer at a time on a multiplexed byte-wide bus. The low address byte and the data byte share one port. An address-latch strobe marks when the low address is valid on that port. The high address byte sits on a second port for the whole transfer. Separate active-low read and write strobes select the direction.

A 3-bit stretch code picks how long each transfer lasts. The mapping is deliberately non-linear:

- Code 0 gives the shortest transfer.
- Code 1 adds one system clock of setup before the strobe and one system clock of hold after it.
- Codes 2 and 3 only lengthen the strobe.
- Codes 4 to 7 add one full stretch machine cycle each to the latch pulse, the setup and the hold, and they also lengthen the strobe.

The block counts everything in ticks of its own clock. One tick is half a system clock, and one stretch machine cycle is eight ticks.

Requests use a valid/ready handshake. The block holds `req_ready` high only while it is idle. A requester that sees ready low must keep its valid high and its fields stable. The result leaves as a single-tick `rsp_valid` pulse carrying `rsp_rdata`. There is no back-pressure on this pulse, so the consumer must take it in the tick it appears.

Top module: `xbus_stretch_ctrl`

## Requirements
- R1: `req_ready` is 1 exactly when no transfer is in progress. A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` reads 0 from the next tick until the transfer completes.
- R2: In the first ticks after acceptance, `bus_ale` is 1, `p0_oe` is 1 and `p0_out` carries address bits 7:0. `p2_out` carries address bits 15:8 in every busy tick.
- R3: The active strobe is low for 2 ticks at code 0, and for 4×code ticks at codes 1 to 7 (4, 8, 12, 16, 20, 24, 28).
- R4: The setup ticks between the fall of `bus_ale` and the start of the strobe are 2 at code 0, 4 at codes 1 to 3, and 12 at codes 4 to 7.
- R5: The hold ticks after the strobe ends, before completion, are 2 at code 0, 4 at codes 1 to 3, and 12 at codes 4 to 7.
- R6: `bus_ale` stays high for 2 ticks at codes 0 to 3 and for 10 ticks at codes 4 to 7.
- R7: In a write (`req_write`=1), `p0_oe` stays 1 and `p0_out` equals the write data in every busy tick after `bus_ale` falls. In a read, `p0_oe` is 0 after `bus_ale` falls. `rsp_rdata` is the `p0_in` value present in the last tick that `rd_n` is low.
- R8: `rsp_valid` is 1 for exactly one tick, in the first tick after the hold phase.
- R9: `cfg_stretch` is sampled only at acceptance. Changing it during a transfer does not alter that transfer's timing.
- R10: Only `rd_n` goes low in a read and only `wr_n` in a write. When idle, both strobes are 1, `bus_ale` is 0 and `p0_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock (twice the system-clock rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_stretch | input | 3 | Stretch code, sampled at acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, can accept |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-tick completion pulse |
| rsp_rdata | output | 8 | Read data captured during strobe |
| bus_ale | output | 1 | Address latch strobe, active high |
| p0_out | output | 8 | Low address / write data drive |
| p0_oe | output | 1 | Output enable for the shared byte port |
| p0_in | input | 8 | Shared byte port input |
| p2_out | output | 8 | High address byte |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Two behaviours are hard to reach from the ports.

The first is that the stretch code is frozen for the length of a transfer. To show this, the stimulus flips the top bit of `cfg_stretch` one tick after every acceptance. Each vector's measured phase lengths must still match the code that was present at acceptance, even though the flipped code moves between the short and long timing groups.

The second is the exact capture tick for read data. The bench model drives a marker byte on `p0_in` only while `rd_n` is low, and drives a different byte otherwise. A capture one tick late therefore returns the wrong value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE    = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_t;

  typedef struct packed {
    logic [CNT_W-1:0] ale;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] hold;
  } profile_t;

endpackage

// File: rtl/xbus_stretch_decode.sv
module xbus_stretch_decode
  import xbus_pkg::*;
#(
  parameter int BASE_TICKS    = 2,
  parameter int SYS_TICKS     = 2,
  parameter int STRETCH_TICKS = 8,
  parameter int UNIT_STROBE   = 4
) (
  input  logic [2:0] code,
  output profile_t   prof
);

  localparam int LONG_ALE = BASE_TICKS + STRETCH_TICKS;
  localparam int MID_EDGE = BASE_TICKS + SYS_TICKS;
  localparam int LONG_EDGE = MID_EDGE + STRETCH_TICKS;

  always_comb begin
    // Latch pulse: only the slow group widens it.
    prof.ale = code[2] ? CNT_W'(LONG_ALE) : CNT_W'(BASE_TICKS);

    // Setup and hold grow symmetrically.
    if (code == 3'd0) begin
      prof.setup = CNT_W'(BASE_TICKS);
      prof.hold  = CNT_W'(BASE_TICKS);
    end else if (!code[2]) begin
      prof.setup = CNT_W'(MID_EDGE);
      prof.hold  = CNT_W'(MID_EDGE);
    end else begin
      prof.setup = CNT_W'(LONG_EDGE);
      prof.hold  = CNT_W'(LONG_EDGE);
    end

    // Strobe width.
    if (code == 3'd0) prof.strobe = CNT_W'(BASE_TICKS);
    else              prof.strobe = CNT_W'(UNIT_STROBE * int'(code));
  end

endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  profile_t prof_in,
  output phase_t   phase,
  output logic     strobe_last,
  output logic     done
);

  profile_t         prof_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      done   <= 1'b0;
      prof_q <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            prof_q <= prof_in;
            phase  <= PH_ALE;
            cnt    <= prof_in.ale - CNT_W'(1);
          end
        end
        PH_ALE: begin
          if (cnt == '0) begin
            phase <= PH_SETUP;
            cnt   <= prof_q.setup - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_STROBE;
            cnt   <= prof_q.strobe - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            phase <= PH_HOLD;
            cnt   <= prof_q.hold - CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign strobe_last = (phase == PH_STROBE) && (cnt == '0);

  // R9: the latched profile must not move while a transfer runs.
  p_profile_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) && ($past(phase) != PH_IDLE) |-> $stable(prof_q));

  // R8: completion only ever follows the hold phase.
  p_done_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phase) != PH_HOLD |-> !done);

endmodule

// File: rtl/xbus_port_driver.sv
module xbus_port_driver
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              write_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  phase_t            phase,
  input  logic              strobe_last,
  input  logic [DATA_W-1:0] p0_in,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_ale,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [ADDR_W-DATA_W-1:0] p2_out,
  output logic              rd_n,
  output logic              wr_n
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_in;
        wdata_q <= wdata_in;
        write_q <= write_in;
      end
      if (strobe_last && !write_q) rdata <= p0_in;
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign bus_ale = (phase == PH_ALE);
  assign p2_out  = busy ? addr_q[ADDR_W-1:DATA_W] : '0;
  assign p0_oe   = bus_ale || (busy && write_q);

  always_comb begin
    if (bus_ale)               p0_out = addr_q[DATA_W-1:0];
    else if (busy && write_q)  p0_out = wdata_q;
    else                       p0_out = '0;
  end

  assign rd_n = !((phase == PH_STROBE) && !write_q);
  assign wr_n = !((phase == PH_STROBE) && write_q);

  // R7: the shared port is released while the read strobe is low.
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);

  // R2: address phase always drives the shared port.
  p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> p0_oe && rd_n && wr_n);

endmodule

// File: rtl/xbus_stretch_ctrl.sv
module xbus_stretch_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int BASE_TICKS    = 2,
  parameter int SYS_TICKS     = 2,
  parameter int STRETCH_TICKS = 8,
  parameter int UNIT_STROBE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_stretch,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_ale,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  input  logic [DATA_W-1:0] p0_in,
  output logic [ADDR_W-DATA_W-1:0] p2_out,
  output logic              rd_n,
  output logic              wr_n
);

  profile_t prof;
  phase_t   phase;
  logic     strobe_last;
  logic     accept;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  xbus_stretch_decode #(
    .BASE_TICKS    (BASE_TICKS),
    .SYS_TICKS     (SYS_TICKS),
    .STRETCH_TICKS (STRETCH_TICKS),
    .UNIT_STROBE   (UNIT_STROBE)
  ) u_decode (
    .code (cfg_stretch),
    .prof (prof)
  );

  xbus_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .prof_in     (prof),
    .phase       (phase),
    .strobe_last (strobe_last),
    .done        (rsp_valid)
  );

  xbus_port_driver #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .addr_in     (req_addr),
    .write_in    (req_write),
    .wdata_in    (req_wdata),
    .phase       (phase),
    .strobe_last (strobe_last),
    .p0_in       (p0_in),
    .rdata       (rsp_rdata),
    .bus_ale     (bus_ale),
    .p0_out      (p0_out),
    .p0_oe       (p0_oe),
    .p2_out      (p2_out),
    .rd_n        (rd_n),
    .wr_n        (wr_n)
  );

  // R1: an accepted request makes the block busy on the next tick.
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R8: completion is a single-tick pulse.
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: never both strobes; idle keeps the bus quiet.
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> rd_n && wr_n && !bus_ale && !p0_oe);

endmodule

// File: tb/tb_xbus_stretch_ctrl.sv
module tb_xbus_stretch_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_stretch = 3'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        bus_ale;
  logic [7:0]  p0_out;
  logic        p0_oe;
  logic [7:0]  p0_in;
  logic [7:0]  p2_out;
  logic        rd_n;
  logic        wr_n;
  logic [7:0]  rd_model = 8'h00;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // Memory model: marker only while read strobe low.
  assign p0_in = rd_n ? 8'hEE : rd_model;

  xbus_stretch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_stretch(cfg_stretch),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bus_ale(bus_ale), .p0_out(p0_out),
    .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out), .rd_n(rd_n), .wr_n(wr_n)
  );

  // code(3) write(1) addr(16) data(8)
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h12A5, 8'h3C},
    {3'd0, 1'b1, 16'h8001, 8'h5A},
    {3'd1, 1'b0, 16'hFF00, 8'hC3},
    {3'd1, 1'b1, 16'h00FF, 8'h81},
    {3'd2, 1'b1, 16'h4567, 8'h0F},
    {3'd3, 1'b0, 16'hBEEF, 8'hF0},
    {3'd4, 1'b1, 16'hA55A, 8'h69},
    {3'd5, 1'b0, 16'h0102, 8'h96},
    {3'd6, 1'b1, 16'h7E7E, 8'hAA},
    {3'd7, 1'b0, 16'hC0DE, 8'h55}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ale(input logic [2:0] c);
    return c[2] ? 10 : 2;
  endfunction
  function automatic int exp_edge(input logic [2:0] c);
    if (c == 3'd0) return 2;
    return c[2] ? 12 : 4;
  endfunction
  function automatic int exp_strobe(input logic [2:0] c);
    return (c == 3'd0) ? 2 : 4 * int'(c);
  endfunction

  task automatic run(input logic [2:0] code, input logic wr,
                     input logic [15:0] addr, input logic [7:0] data);
    int a = 0, pre = 0, s = 0, post = 0, n = 0;
    bit bad_addr = 0, bad_p2 = 0, bad_dir = 0, bad_rdy = 0, bad_wd = 0;
    @(negedge clk);
    cfg_stretch = code;
    req_addr = addr; req_write = wr; req_wdata = data; rd_model = data;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = ~addr; req_wdata = ~data;
    cfg_stretch = code ^ 3'b100;  // mid-transfer change (R9)
    while (!rsp_valid && n < 200) begin
      n++;
      if (req_ready) bad_rdy = 1;
      if (p2_out != addr[15:8]) bad_p2 = 1;
      if (bus_ale) begin
        a++;
        if (!p0_oe || p0_out != addr[7:0]) bad_addr = 1;
      end else begin
        if (wr && (!p0_oe || p0_out != data)) bad_wd = 1;
        if (!wr && p0_oe) bad_wd = 1;
        if ((wr && !wr_n) || (!wr && !rd_n)) s++;
        else if (s == 0) pre++;
        else post++;
      end
      if ((wr && !rd_n) || (!wr && !wr_n)) bad_dir = 1;
      @(negedge clk);
    end
    check(rsp_valid, "R8 completion pulse", rsp_valid, 1);
    check(!bad_rdy, "R1 ready low while busy", bad_rdy, 0);
    check(!bad_addr && !bad_p2, "R2 address on ports", {bad_addr, bad_p2}, 0);
    check(s == exp_strobe(code), "R3 strobe width", s, exp_strobe(code));
    check(pre == exp_edge(code), "R4 setup ticks", pre, exp_edge(code));
    check(post == exp_edge(code), "R5 hold ticks", post, exp_edge(code));
    check(a == exp_ale(code), "R6 latch width", a, exp_ale(code));
    check(!bad_wd, "R7 port drive by direction", bad_wd, 0);
    check(!bad_dir, "R10 wrong strobe active", bad_dir, 0);
    if (!wr) check(rsp_rdata == data, "R7 read capture", rsp_rdata, data);
    check(req_ready, "R1 ready at completion", req_ready, 1);
    @(negedge clk);
    check(!rsp_valid, "R8 pulse one tick", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R1, R8, R10)
    check(req_ready, "R1 ready in reset", req_ready, 1);
    check(rd_n && wr_n, "R10 strobes idle in reset", {rd_n, wr_n}, 3);
    check(!bus_ale && !p0_oe, "R10 bus quiet in reset", {bus_ale, p0_oe}, 0);
    check(!rsp_valid, "R8 no pulse in reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && rd_n && wr_n && !p0_oe, "R10 idle after reset",
          {req_ready, rd_n, wr_n, p0_oe}, 4'b1110);

    for (int i = 0; i < NV; i++)
      run(VEC[i][27:25], VEC[i][24], VEC[i][23:8], VEC[i][7:0]);

    // Corner: back-to-back extremes, longest then shortest (R9, R3)
    run(3'd7, 1'b1, 16'hFFFF, 8'hFF);
    run(3'd0, 1'b0, 16'h0000, 8'h00);

    // Valid low while idle: nothing starts (R1)
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(req_ready && !bus_ale, "R1 no start without valid",
          {req_ready, bus_ale}, 2'b10);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule